// File: doc/BRIEF.md
# Triggered Injected-Channel Conversion Sequencer

This block runs a short, high-priority burst of one to four analog-to-digital conversions. A single 32-bit configuration word sets the burst length, chooses one of 32 external event lines as the hardware trigger, picks the trigger edge (rising, falling, both or none), and names the channel for each of four slots. A burst starts on a software start pulse or on the chosen edge of the selected event line. The block then asks the converter for one conversion per slot, in slot order.

For each conversion the block raises a request and holds the channel number on its output. It keeps both steady until the converter returns a one-cycle done pulse. A busy flag covers the whole burst, and configuration writes made while it is set are dropped. After the last slot's done, a one-cycle end pulse is issued and busy falls in the same cycle. A queue mode input, combined with a queue-empty indication, blocks every kind of start. A slot value outside the legal channel range 0 to 19 is still sent to the converter, and an error flag is raised alongside that request.

Top module: `inj_seq`

## Requirements
- R1: After reset the configuration word reads as zero, and busy, request and end are low. The word uses this layout: length in bits [1:0], event select in [6:2], edge code in [8:7], slot 1 in [13:9], slot 2 in [19:15], slot 3 in [25:21] and slot 4 in [31:27]. Bits 14, 20 and 26 always read zero.
- R2: A length field value L gives exactly L+1 conversions in each burst.
- R3: Conversions run in slot order: slot 1 first, then slot 2, slot 3 and slot 4, stopping at the programmed length. Each request carries that slot's channel number.
- R4: A request and its channel stay steady until a done pulse arrives. The next slot's request follows on the cycle after that done.
- R5: A configuration write made while busy is high leaves the stored word unchanged.
- R6: Edge code 00 ignores the event line. Code 01 starts a burst on a rising edge, 10 on a falling edge and 11 on either edge. The event passes through two synchronizing flops, so busy rises on the third clock edge after the event input changes.
- R7: The event select field picks which of the 32 event lines is watched. Edges on the other lines have no effect.
- R8: On the cycle after the last done, the end output pulses high for one cycle and busy is low.
- R9: A slot value above 19 is sent unchanged on the channel output, and the error output is high for as long as that request is up.
- R10: While queue mode and queue-empty are both high, neither a software start nor an event edge starts a burst.
- R11: A software start begins a burst when the block is idle, even when the edge code is 00. A software start while busy is dropped.
- R12: An event edge that arrives during a burst is dropped and does not start a burst later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Stored configuration word |
| sw_start | input | 1 | Software start pulse |
| queue_mode | input | 1 | Queue mode enable |
| queue_empty | input | 1 | Queue empty indication |
| ext_evt | input | 32 | External event lines |
| conv_req | output | 1 | Conversion request |
| conv_chan | output | 5 | Channel number for the current request |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_err | output | 1 | Current channel number is out of range |
| seq_busy | output | 1 | Burst in progress |
| seq_end | output | 1 | One-cycle end-of-burst pulse |

## Verification
A software start, like a configuration write, takes effect at the first clock edge that samples it, so busy, request and the stored word are checked one half-cycle after that edge. An event line change needs three edges before busy rises: the bench drives it on a falling edge and checks that busy is still low at each of the next two falling edges, then high at the third. A done pulse driven before an edge moves the channel output to the next slot after that edge, or, for the last slot, shows end high and busy low at the next falling edge. End is then checked low one cycle later. Rejected starts are confirmed by watching busy stay low for several cycles past the point where it would have risen.

// File: rtl/inj_seq_pkg.sv
package inj_seq_pkg;

    localparam int unsigned CH_W   = 5;
    localparam int unsigned LEN_W  = 2;
    localparam int unsigned SEL_W  = 5;
    localparam int unsigned POL_W  = 2;
    localparam int unsigned WORD_W = 32;

    // edge code values
    localparam logic [POL_W-1:0] EDGE_OFF  = 2'b00;
    localparam logic [POL_W-1:0] EDGE_RISE = 2'b01;
    localparam logic [POL_W-1:0] EDGE_FALL = 2'b10;
    localparam logic [POL_W-1:0] EDGE_BOTH = 2'b11;

    // configuration word layout, MSB first
    typedef struct packed {
        logic [CH_W-1:0]  slot4;
        logic             gap3;
        logic [CH_W-1:0]  slot3;
        logic             gap2;
        logic [CH_W-1:0]  slot2;
        logic             gap1;
        logic [CH_W-1:0]  slot1;
        logic [POL_W-1:0] edge_code;
        logic [SEL_W-1:0] evt_sel;
        logic [LEN_W-1:0] len;
    } cfg_word_t;

endpackage

// File: rtl/inj_seq_cfg.sv
module inj_seq_cfg
    import inj_seq_pkg::*;
#(
    parameter int unsigned N_SLOT = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [WORD_W-1:0]                 wdata,
    input  logic                              lock,
    output logic [WORD_W-1:0]                 rdata,
    output logic [LEN_W-1:0]                  len,
    output logic [SEL_W-1:0]                  evt_sel,
    output logic [POL_W-1:0]                  edge_code,
    output logic [N_SLOT-1:0][CH_W-1:0]       slots
);

    typedef struct packed {
        cfg_word_t word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    cfg_word_t  wr_word;

    always_comb begin
        wr_word      = cfg_word_t'(wdata);
        wr_word.gap1 = 1'b0;
        wr_word.gap2 = 1'b0;
        wr_word.gap3 = 1'b0;

        st_d = st_q;
        if (we && !lock) begin
            st_d.word = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.word;
    assign len       = st_q.word.len;
    assign evt_sel   = st_q.word.evt_sel;
    assign edge_code = st_q.word.edge_code;

    always_comb begin
        slots = '0;
        slots[0] = st_q.word.slot1;
        if (N_SLOT > 1) slots[1 % N_SLOT] = st_q.word.slot2;
        if (N_SLOT > 2) slots[2 % N_SLOT] = st_q.word.slot3;
        if (N_SLOT > 3) slots[3 % N_SLOT] = st_q.word.slot4;
    end

endmodule

// File: rtl/inj_seq_trig.sv
module inj_seq_trig
    import inj_seq_pkg::*;
#(
    parameter int unsigned N_EVT       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_EVT-1:0]     evt,
    input  logic [SEL_W-1:0]     evt_sel,
    input  logic [POL_W-1:0]     edge_code,
    output logic                 hw_edge
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0][N_EVT-1:0] sync;
        logic [N_EVT-1:0]                  prev;
    } trig_state_t;

    trig_state_t st_d, st_q;
    logic        cur_lvl, old_lvl;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = evt;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        // keep the last level of every line so a select change makes no edge
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cur_lvl = st_q.sync[SYNC_STAGES-1][evt_sel];
        old_lvl = st_q.prev[evt_sel];
        unique case (edge_code)
            EDGE_RISE: hw_edge = cur_lvl & ~old_lvl;
            EDGE_FALL: hw_edge = ~cur_lvl & old_lvl;
            EDGE_BOTH: hw_edge = cur_lvl ^ old_lvl;
            default:   hw_edge = 1'b0;
        endcase
    end

endmodule

// File: rtl/inj_seq_fsm.sv
module inj_seq_fsm
    import inj_seq_pkg::*;
#(
    parameter int unsigned N_SLOT = 4,
    parameter int unsigned MAX_CH = 19
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [LEN_W-1:0]              len,
    input  logic [N_SLOT-1:0][CH_W-1:0]   slots,
    input  logic                          conv_done,
    output logic                          conv_req,
    output logic [CH_W-1:0]               conv_chan,
    output logic                          conv_err,
    output logic                          busy,
    output logic                          fin
);

    localparam int unsigned IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    typedef struct packed {
        logic             busy;
        logic             req;
        logic [IDX_W-1:0] idx;
        logic             fin;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       last_slot;

    assign last_slot = (IDX_W'(st_q.idx) == IDX_W'(len));

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.req  = 1'b1;
                st_d.idx  = '0;
            end
        end else if (st_q.req && conv_done) begin
            if (last_slot) begin
                st_d.busy = 1'b0;
                st_d.req  = 1'b0;
                st_d.idx  = '0;
                st_d.fin  = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign conv_req  = st_q.req;
    assign conv_chan = slots[st_q.idx];
    assign conv_err  = st_q.req && (conv_chan > CH_W'(MAX_CH));
    assign busy      = st_q.busy;
    assign fin       = st_q.fin;

endmodule

// File: rtl/inj_seq.sv
module inj_seq
    import inj_seq_pkg::*;
#(
    parameter int unsigned N_EVT       = 32,
    parameter int unsigned N_SLOT      = 4,
    parameter int unsigned MAX_CH      = 19,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              sw_start,
    input  logic              queue_mode,
    input  logic              queue_empty,
    input  logic [31:0]       ext_evt,
    output logic              conv_req,
    output logic [4:0]        conv_chan,
    input  logic              conv_done,
    output logic              conv_err,
    output logic              seq_busy,
    output logic              seq_end
);

    logic [LEN_W-1:0]            len;
    logic [SEL_W-1:0]            evt_sel;
    logic [POL_W-1:0]            edge_code;
    logic [N_SLOT-1:0][CH_W-1:0] slots;
    logic                        hw_edge;
    logic                        trig_block;
    logic                        go;

    inj_seq_cfg #(.N_SLOT(N_SLOT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .lock      (seq_busy),
        .rdata     (cfg_rdata),
        .len       (len),
        .evt_sel   (evt_sel),
        .edge_code (edge_code),
        .slots     (slots)
    );

    inj_seq_trig #(.N_EVT(N_EVT), .SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (ext_evt[N_EVT-1:0]),
        .evt_sel   (evt_sel),
        .edge_code (edge_code),
        .hw_edge   (hw_edge)
    );

    assign trig_block = queue_mode & queue_empty;
    assign go         = ~trig_block & (sw_start | hw_edge);

    inj_seq_fsm #(.N_SLOT(N_SLOT), .MAX_CH(MAX_CH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (go),
        .len       (len),
        .slots     (slots),
        .conv_done (conv_done),
        .conv_req  (conv_req),
        .conv_chan (conv_chan),
        .conv_err  (conv_err),
        .busy      (seq_busy),
        .fin       (seq_end)
    );

endmodule

// File: rtl/inj_seq_chk.sv
module inj_seq_chk #(
    parameter int unsigned MAX_CH = 19
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rdata,
    input logic        queue_mode,
    input logic        queue_empty,
    input logic        conv_req,
    input logic [4:0]  conv_chan,
    input logic        conv_done,
    input logic        conv_err,
    input logic        seq_busy,
    input logic        seq_end
);

    // R5: word frozen across any edge at which busy was set
    p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> $stable(cfg_rdata));

    // R4: request and channel hold until done
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_chan)));

    // R4: request only inside a burst
    p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> seq_busy);

    // R8: end pulse lasts one cycle with busy low
    p_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |-> (!seq_busy && !conv_req));
    p_end_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_end |=> !seq_end);

    // R9: error only for an out-of-range channel under request
    p_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conv_err |-> (conv_req && (conv_chan > 5'(MAX_CH))));

    // R10: no start while queue mode sees an empty queue
    p_qblock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_busy && queue_mode && queue_empty) |=> !seq_busy);

endmodule

bind inj_seq inj_seq_chk #(.MAX_CH(MAX_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .queue_mode  (queue_mode),
    .queue_empty (queue_empty),
    .conv_req    (conv_req),
    .conv_chan   (conv_chan),
    .conv_done   (conv_done),
    .conv_err    (conv_err),
    .seq_busy    (seq_busy),
    .seq_end     (seq_end)
);

// File: tb/inj_seq_test.sv
`timescale 1ns/1ps
module inj_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sw_start = 1'b0;
    logic        queue_mode = 1'b0;
    logic        queue_empty = 1'b0;
    logic [31:0] ext_evt = '0;
    logic        conv_req;
    logic [4:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic        conv_err;
    logic        seq_busy;
    logic        seq_end;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;
    logic [4:0] exp_ch [4];

    always #2.5 clk = ~clk;

    inj_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sw_start(sw_start), .queue_mode(queue_mode),
        .queue_empty(queue_empty), .ext_evt(ext_evt), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_err(conv_err),
        .seq_busy(seq_busy), .seq_end(seq_end)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int len, input int sel, input int pol,
                                       input int s1, input int s2, input int s3, input int s4);
        logic [31:0] w = '0;
        w[1:0]   = len[1:0];
        w[6:2]   = sel[4:0];
        w[8:7]   = pol[1:0];
        w[13:9]  = s1[4:0];
        w[19:15] = s2[4:0];
        w[25:21] = s3[4:0];
        w[31:27] = s4[4:0];
        return w;
    endfunction

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic sw_pulse();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    // converter model: serves n requests; caller is one negedge after start edge
    task automatic serve(input int n, input int hold, input string req);
        for (int i = 0; i < n; i++) begin
            check(conv_req === 1'b1, req, "request up", {31'd0, conv_req}, 32'd1);
            check(conv_chan === exp_ch[i], req, "slot channel", {27'd0, conv_chan}, {27'd0, exp_ch[i]});
            for (int h = 0; h < hold; h++) @(negedge clk);
            check(conv_req === 1'b1 && conv_chan === exp_ch[i], "R4", "held until done",
                  {27'd0, conv_chan}, {27'd0, exp_ch[i]});
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
        end
        check(seq_end === 1'b1 && seq_busy === 1'b0, "R8", "end pulse, busy low",
              {30'd0, seq_end, seq_busy}, 32'h2);
        check(conv_req === 1'b0, "R2", "no extra request", {31'd0, conv_req}, 32'd0);
        @(negedge clk);
        check(seq_end === 1'b0, "R8", "end one cycle", {31'd0, seq_end}, 32'd0);
    endtask

    // drives event line b to v at a negedge; checks latency and outcome
    task automatic evt_drive(input int b, input logic v, input bit expect_go, input string req);
        @(negedge clk); ext_evt[b] = v;
        @(negedge clk);
        @(negedge clk);
        check(seq_busy === 1'b0, "R6", "two-flop latency", {31'd0, seq_busy}, 32'd0);
        @(negedge clk);
        check(seq_busy === expect_go, req, "edge outcome", {31'd0, seq_busy}, {31'd0, expect_go});
        if (expect_go) serve(1, 1, req);
        else begin
            repeat (3) @(negedge clk);
            check(seq_busy === 1'b0, req, "stays idle", {31'd0, seq_busy}, 32'd0);
        end
    endtask

    task automatic t_reset();
        check(cfg_rdata === 32'd0, "R1", "reset word", cfg_rdata, 32'd0);
        check(seq_busy === 1'b0 && conv_req === 1'b0 && seq_end === 1'b0, "R1", "reset flags",
              {29'd0, seq_busy, conv_req, seq_end}, 32'd0);
    endtask

    task automatic t_layout();
        wr(32'hFFFF_FFFF);
        check(cfg_rdata === 32'hFBEF_BFFF, "R1", "gap bits zero", cfg_rdata, 32'hFBEF_BFFF);
        wr(mk(2, 9, 1, 4, 5, 6, 7));
        check(cfg_rdata === mk(2, 9, 1, 4, 5, 6, 7), "R1", "field layout", cfg_rdata, mk(2, 9, 1, 4, 5, 6, 7));
    endtask

    task automatic t_lengths();
        exp_ch[0] = 5'd3; exp_ch[1] = 5'd7; exp_ch[2] = 5'd11; exp_ch[3] = 5'd19;
        for (int l = 0; l < 4; l++) begin
            wr(mk(l, 0, 0, 3, 7, 11, 19));
            sw_pulse();  // R11: accepted with edge code 00
            check(seq_busy === 1'b1, "R11", "sw start idle", {31'd0, seq_busy}, 32'd1);
            serve(l + 1, 2, "R3");
        end
    endtask

    task automatic t_lock();
        exp_ch[0] = 5'd1; exp_ch[1] = 5'd2;
        wr(mk(1, 0, 0, 1, 2, 0, 0));
        sw_pulse();
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk(3, 4, 3, 9, 9, 9, 9); sw_start = 1'b1;
        @(negedge clk); cfg_we = 1'b0; sw_start = 1'b0;
        check(cfg_rdata === mk(1, 0, 0, 1, 2, 0, 0), "R5", "write while busy", cfg_rdata, mk(1, 0, 0, 1, 2, 0, 0));
        serve(2, 1, "R5");
        repeat (3) @(negedge clk);
        check(seq_busy === 1'b0, "R11", "busy start dropped", {31'd0, seq_busy}, 32'd0);
        check(cfg_rdata === mk(1, 0, 0, 1, 2, 0, 0), "R5", "word after burst", cfg_rdata, mk(1, 0, 0, 1, 2, 0, 0));
    endtask

    task automatic t_edges();
        exp_ch[0] = 5'd2;
        wr(mk(0, 5, 0, 2, 0, 0, 0));
        evt_drive(5, 1'b1, 1'b0, "R6");
        evt_drive(5, 1'b0, 1'b0, "R6");
        wr(mk(0, 5, 1, 2, 0, 0, 0));
        evt_drive(5, 1'b1, 1'b1, "R6");
        evt_drive(5, 1'b0, 1'b0, "R6");
        wr(mk(0, 5, 2, 2, 0, 0, 0));
        evt_drive(5, 1'b1, 1'b0, "R6");
        evt_drive(5, 1'b0, 1'b1, "R6");
        wr(mk(0, 5, 3, 2, 0, 0, 0));
        evt_drive(5, 1'b1, 1'b1, "R6");
        evt_drive(5, 1'b0, 1'b1, "R6");
    endtask

    task automatic t_select();
        exp_ch[0] = 5'd8;
        wr(mk(0, 20, 1, 8, 0, 0, 0));
        evt_drive(5, 1'b1, 1'b0, "R7");
        evt_drive(20, 1'b1, 1'b1, "R7");
        wr(mk(0, 31, 1, 8, 0, 0, 0));
        evt_drive(31, 1'b1, 1'b1, "R7");
        ext_evt = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_err();
        wr(mk(1, 0, 0, 25, 19, 0, 0));
        sw_pulse();
        check(conv_chan === 5'd25 && conv_err === 1'b1, "R9", "out of range flagged",
              {26'd0, conv_err, conv_chan}, {26'd1, 5'd25});
        conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        check(conv_chan === 5'd19 && conv_err === 1'b0, "R9", "19 legal",
              {26'd0, conv_err, conv_chan}, {26'd0, 5'd19});
        conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
        check(conv_err === 1'b0 && seq_end === 1'b1, "R9", "error clears", {30'd0, conv_err, seq_end}, 32'd1);
    endtask

    task automatic t_queue();
        exp_ch[0] = 5'd6;
        wr(mk(0, 3, 1, 6, 0, 0, 0));
        queue_mode = 1'b1; queue_empty = 1'b1;
        sw_pulse();
        check(seq_busy === 1'b0, "R10", "sw blocked", {31'd0, seq_busy}, 32'd0);
        evt_drive(3, 1'b1, 1'b0, "R10");
        ext_evt[3] = 1'b0;
        repeat (4) @(negedge clk);
        queue_empty = 1'b0;
        sw_pulse();
        check(seq_busy === 1'b1, "R10", "queue refilled", {31'd0, seq_busy}, 32'd1);
        serve(1, 1, "R10");
        queue_mode = 1'b0;
    endtask

    task automatic t_busy_edge();
        exp_ch[0] = 5'd12;
        wr(mk(0, 7, 1, 12, 0, 0, 0));
        sw_pulse();
        ext_evt[7] = 1'b1;
        serve(1, 6, "R12");
        repeat (6) @(negedge clk);
        check(seq_busy === 1'b0, "R12", "edge in burst dropped", {31'd0, seq_busy}, 32'd0);
        ext_evt[7] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_lengths();
        t_lock();
        t_edges();
        t_select();
        t_err();
        t_queue();
        t_busy_edge();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule